// File: doc/BRIEF.md
# Display-File Fetch Pixel Generator

This block sits beside an 8-bit CPU whose character screen is drawn by letting the CPU run through a text buffer as if it were code. When the CPU fetches an opcode from the upper half of the address space, the block hands the CPU a no-operation byte and keeps the real byte as a character code. The CPU's own refresh cycle then reads the glyph row. During that cycle the block builds the character-ROM address from the high refresh-address bits, six bits of the character code and a scanline counter.

At the next opcode fetch the returned glyph row goes into a shift register. The register sends one pixel per dot clock, most significant bit first. Bit 7 of the character code turns the cell inverse. A byte with bit 6 set, such as the halt opcode 0x76, reaches the CPU unchanged and ends the character row. The dot clock `clk` runs at twice the CPU clock, so one four-state no-op fetch lasts eight dot clocks and produces one character cell.

Top module: `dfile_pixel_gen`

## Requirements
- R1: While `opfetch`, `mreq` and `cpu_addr[15]` are high, `alt_data[6]` is low and `halt` is low, `cpu_data` is 0x00.
- R2: Under any other condition, `cpu_data` equals `alt_data`. This includes a fetched byte with bit 6 set (0x76), an asserted `halt` and a fetch with `cpu_addr[15]` low.
- R3: The character code is taken from `alt_data` on every clock where `rfsh` is low, `cpu_phase` is high and `mreq` is high. The last such capture before refresh is the one used, so a T2 capture replaces the earlier T1 capture.
- R4: While `rfsh` is high, `rom_addr` is {`cpu_addr[ROM_AW-1:9]`, code[5:0], line[2:0]} and `rom_sel` is high.
- R5: While `rfsh` is low, `rom_addr` equals `cpu_addr[ROM_AW-1:0]` and `rom_sel` equals `mreq` AND NOT `cpu_addr[14]`.
- R6: On the first clock after `rfsh` falls, if the preceding fetch forced a no-op, `alt_data` is loaded as the glyph row. `pixel` is registered and shows glyph bits 7 down to 0, one per clock, on the 8 clocks that follow. It is 0 after reset.
- R7: When bit 7 of the character code is 1, every pixel of that cell is inverted. The invert state is replaced at the next load point.
- R8: A cell whose fetch did not force a no-op loads nothing and is not inverted. Its pixels come from `serial_in` shifted through the register.
- R9: The 3-bit scanline counter clears on a clock with `frame_top` high. Otherwise it increments on a clock with `line_step` high and wraps from 7 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock, twice the CPU clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_phase | input | 1 | CPU clock level, high in the first dot clock of each T-state |
| opfetch | input | 1 | CPU opcode fetch in progress (T1, T2) |
| mreq | input | 1 | CPU memory request active |
| rfsh | input | 1 | CPU refresh cycle active (T3, T4) |
| halt | input | 1 | CPU halted |
| cpu_addr | input | 16 | CPU address bus |
| alt_data | input | 8 | Memory-side data bus |
| line_step | input | 1 | Advance the scanline counter |
| frame_top | input | 1 | Clear the scanline counter |
| serial_in | input | 1 | Fill bit for the shift register |
| cpu_data | output | 8 | CPU-side data bus |
| rom_addr | output | ROM_AW | Character/system ROM address |
| rom_sel | output | 1 | ROM chip select |
| pixel | output | 1 | Registered pixel stream |

## Verification
The bench builds the block with its default `ROM_AW` of 13, which gives four refresh-address bits above the code and line fields. It varies the refresh address from cell to cell so that all three fields of R4 can be observed at once. With the 8K width, the ROM select in R5 can be seen both for a low-half fetch and for a fetch at an address with bit 14 set. The bench also moves the scanline counter through its wrap from 7 to 0 and through a clear, and it switches the serial fill between 0 and 1 between blank cells.

// File: rtl/dfile_pixel_gen.sv
module dfile_pixel_gen #(
  parameter int ROM_AW = 13,
  parameter int LINE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_phase,
  input  logic              opfetch,
  input  logic              mreq,
  input  logic              rfsh,
  input  logic              halt,
  input  logic [15:0]       cpu_addr,
  input  logic [7:0]        alt_data,
  input  logic              line_step,
  input  logic              frame_top,
  input  logic              serial_in,
  output logic [7:0]        cpu_data,
  output logic [ROM_AW-1:0] rom_addr,
  output logic              rom_sel,
  output logic              pixel
);
  localparam int CODE_W = 6;
  localparam int LO_W   = LINE_W + CODE_W;

  logic [7:0]        code_q;
  logic              pend_q, inv_q, rfsh_q, pix_q;
  logic [7:0]        sh_q;
  logic [LINE_W-1:0] line_q;

  wire nop_force = opfetch & mreq & cpu_addr[15] & ~alt_data[6] & ~halt;
  wire capture   = ~rfsh & cpu_phase & mreq;
  wire load_pt   = rfsh_q & ~rfsh;

  assign cpu_data = nop_force ? 8'h00 : alt_data;
  assign rom_addr = rfsh ? {cpu_addr[ROM_AW-1:LO_W], code_q[CODE_W-1:0], line_q}
                         : cpu_addr[ROM_AW-1:0];
  assign rom_sel  = rfsh | (mreq & ~cpu_addr[14]);
  assign pixel    = pix_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      code_q <= '0;
      pend_q <= 1'b0;
      rfsh_q <= 1'b0;
      line_q <= '0;
    end else begin
      rfsh_q <= rfsh;
      if (capture) begin
        code_q <= alt_data;
        pend_q <= nop_force;
      end
      if (frame_top)      line_q <= '0;
      else if (line_step) line_q <= line_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_q  <= '0;
      inv_q <= 1'b0;
      pix_q <= 1'b0;
    end else if (load_pt && pend_q) begin
      sh_q  <= {alt_data[6:0], serial_in};
      inv_q <= code_q[7];
      pix_q <= alt_data[7] ^ code_q[7];
    end else if (load_pt) begin
      sh_q  <= {sh_q[6:0], serial_in};
      inv_q <= 1'b0;
      pix_q <= sh_q[7];
    end else begin
      sh_q  <= {sh_q[6:0], serial_in};
      pix_q <= sh_q[7] ^ inv_q;
    end
  end
endmodule

// File: rtl/dfile_pixel_gen_chk.sv
module dfile_pixel_gen_chk #(
  parameter int ROM_AW = 13,
  parameter int LINE_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              opfetch,
  input logic              mreq,
  input logic              rfsh,
  input logic              halt,
  input logic [15:0]       cpu_addr,
  input logic [7:0]        alt_data,
  input logic              frame_top,
  input logic [7:0]        cpu_data,
  input logic [ROM_AW-1:0] rom_addr,
  input logic              rom_sel
);
  a_r1_forced_nop: assert property (@(posedge clk) disable iff (!rst_n)
    (opfetch && mreq && cpu_addr[15] && !alt_data[6] && !halt) |-> cpu_data == 8'h00);

  a_r2_pass_through: assert property (@(posedge clk) disable iff (!rst_n)
    (opfetch && mreq && (alt_data[6] || halt || !cpu_addr[15])) |-> cpu_data == alt_data);

  a_r4_refresh_select: assert property (@(posedge clk) disable iff (!rst_n)
    rfsh |-> rom_sel && rom_addr[ROM_AW-1:LINE_W+6] == cpu_addr[ROM_AW-1:LINE_W+6]);

  a_r5_cpu_address: assert property (@(posedge clk) disable iff (!rst_n)
    !rfsh |-> rom_addr == cpu_addr[ROM_AW-1:0]);

  a_r9_line_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (rfsh && $past(frame_top)) |-> rom_addr[LINE_W-1:0] == '0);
endmodule

bind dfile_pixel_gen dfile_pixel_gen_chk #(.ROM_AW(ROM_AW), .LINE_W(LINE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .opfetch(opfetch), .mreq(mreq), .rfsh(rfsh),
  .halt(halt), .cpu_addr(cpu_addr), .alt_data(alt_data), .frame_top(frame_top),
  .cpu_data(cpu_data), .rom_addr(rom_addr), .rom_sel(rom_sel)
);

// File: tb/dfile_pixel_gen_test.sv
module dfile_pixel_gen_test;
  localparam int AW = 13;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cpu_phase = 0, opfetch = 0, mreq = 0, rfsh = 0, halt = 0;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  alt_data = '0;
  logic line_step = 0, frame_top = 0, serial_in = 0;
  logic [7:0]  cpu_data;
  logic [AW-1:0] rom_addr;
  logic rom_sel, pixel;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  int    exp_q[$];
  string tag_q[$];

  logic [7:0] prev_code = 0, prev_glyph = 0;
  bit   prev_forced = 0;
  int   line = 0;
  logic [15:0] raddr = 16'h1A40;

  always #5 clk = ~clk;

  dfile_pixel_gen #(.ROM_AW(AW)) uut (
    .clk(clk), .rst_n(rst_n), .cpu_phase(cpu_phase), .opfetch(opfetch), .mreq(mreq),
    .rfsh(rfsh), .halt(halt), .cpu_addr(cpu_addr), .alt_data(alt_data),
    .line_step(line_step), .frame_top(frame_top), .serial_in(serial_in),
    .cpu_data(cpu_data), .rom_addr(rom_addr), .rom_sel(rom_sel), .pixel(pixel)
  );

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: one expected pixel per clock, sampled at the falling edge
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      int e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      if (e != 2) check(t, pixel, e);
    end
  end

  task automatic run_cell(input logic [15:0] a, input logic [7:0] code, input logic [7:0] glyph,
                          input bit hlt, input bit stp, input bit top, input bit ser);
    bit dc;
    bit fc;
    logic [AW-1:0] ea;
    @(negedge clk);
    dc = (ser != serial_in);
    serial_in = ser; line_step = 0; frame_top = 0;
    opfetch = 1; mreq = 1; rfsh = 0; cpu_phase = 1; halt = hlt;
    cpu_addr = a; alt_data = prev_glyph;
    @(posedge clk);
    for (int k = 0; k < 8; k++) begin
      if (dc) begin exp_q.push_back(2); tag_q.push_back("R8"); end
      else if (prev_forced) begin
        exp_q.push_back(int'(prev_glyph[7-k] ^ prev_code[7]));
        tag_q.push_back(prev_code[7] ? "R7" : "R6");
      end else begin
        exp_q.push_back(int'(ser)); tag_q.push_back("R8");
      end
    end
    @(negedge clk);
    cpu_phase = 0; alt_data = code;
    #1;
    fc = a[15] && !code[6] && !hlt;
    if (fc) check("R1", cpu_data, 8'h00);
    else    check("R2", cpu_data, code);
    check("R5", rom_addr, a[AW-1:0]);
    check("R5", rom_sel, !a[14]);
    @(negedge clk); cpu_phase = 1;
    @(negedge clk); cpu_phase = 0;
    @(negedge clk);
    opfetch = 0; rfsh = 1; cpu_phase = 1; cpu_addr = raddr; alt_data = glyph;
    #1;
    ea = {raddr[AW-1:9], code[5:0], 3'(line)};
    check("R4 R3 R9", rom_addr, ea);
    check("R4", rom_sel, 1);
    @(negedge clk); cpu_phase = 0;
    @(negedge clk); cpu_phase = 1;
    @(negedge clk); cpu_phase = 0; line_step = stp; frame_top = top;
    if (top) line = 0; else if (stp) line = (line + 1) % 8;
    prev_code = code; prev_glyph = glyph; prev_forced = fc;
    raddr = raddr + 16'h0201;
  endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    check("R6", pixel, 0);
    rst_n = 1;
    run_cell(16'hC000, 8'h05, 8'hA5, 0, 0, 0, 0);
    run_cell(16'hC001, 8'h85, 8'h3C, 0, 1, 0, 0);   // R7 inverted cell
    run_cell(16'hC002, 8'h2A, 8'h81, 0, 1, 0, 0);
    run_cell(16'hC003, 8'h76, 8'hFF, 0, 0, 0, 0);   // R2 halt opcode, R8 blank next
    run_cell(16'hC004, 8'h12, 8'h55, 1, 0, 0, 0);   // R2 halt asserted
    run_cell(16'h4000, 8'h21, 8'h77, 0, 0, 0, 1);   // R5 rom_sel low, serial change
    run_cell(16'h0123, 8'h31, 8'h0F, 0, 0, 0, 1);   // R8 serial fill of one
    run_cell(16'hC005, 8'hBF, 8'hC3, 0, 1, 0, 1);
    for (int i = 0; i < 6; i++)                      // R9 wrap
      run_cell(16'hC010 + 16'(i), 8'(8'h08 + i), 8'(8'h90 ^ (i * 13)), 0, 1, 0, 1);
    run_cell(16'hC020, 8'h9A, 8'hE1, 0, 0, 1, 1);   // R9 clear
    run_cell(16'hC021, 8'h0C, 8'h18, 0, 1, 0, 1);
    run_cell(16'h8000, 8'h00, 8'h00, 0, 0, 0, 1);
    run_cell(16'h0000, 8'h40, 8'h00, 0, 0, 0, 1);
    repeat (12) @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule